// File: doc/BRIEF.md
# Vector Saturating Pack Unit

A single-cycle vector execution slice. It recognises two encodings of one saturating pack operation: a standard encoding with 5-bit register fields, and an extended encoding whose 7-bit register indices are assembled from scattered bit fields. It also narrows two vectors of eight signed 16-bit lanes into one 128-bit vector of sixteen byte lanes. Each lane is clamped to the signed byte range or, when the unsigned mode input is high, to the unsigned byte range.

The write-enable and the register indices go to the surrounding register file. The packed result comes out combinationally in the same cycle. One status bit records that some lane was clamped. This bit is sticky: only a dedicated clear input resets it, and the clear input wins over a saturation event in the same cycle.

Top module: `vpack_sat_unit`

## Requirements
- R1: In signed mode (`unsigned_mode_i`=0), each signed 16-bit lane above +127 yields 0x7F, each lane below -128 yields 0x80, and every other lane passes its value unchanged.
- R2: The result is built in big-endian lane order, with byte 0 in `result_o[127:120]`. Source A halfword k (`src_a_i[127-16k -: 16]`) goes to result byte k, and source B halfword k goes to result byte 8+k.
- R3: The standard encoding is recognised when `(instr_i & 32'hFC0007FF) == 32'h1000018E`, and `we_o` is then 1.
- R4: For the standard encoding, the destination index is `instr_i[25:21]`, source A is `instr_i[20:16]` and source B is `instr_i[15:11]`. Each index is zero-extended to 7 bits.
- R5: The extended encoding is recognised when `(instr_i & 32'hFC0003D0) == 32'h14000200`, and `we_o` is then 1.
- R6: For the extended encoding, the indices are assembled as follows: destination = `{instr_i[3:2], instr_i[25:21]}`, source A = `{instr_i[10], instr_i[5], instr_i[20:16]}`, source B = `{instr_i[1:0], instr_i[15:11]}`.
- R7: If an instruction is recognised and at least one lane is clamped, `sat_o` is 1 after the next rising clock edge.
- R8: `sat_o` stays 1 through later instructions, including ones that do not saturate, until a clear is applied.
- R9: A word that matches neither encoding drives `we_o`=0 and leaves `sat_o` unchanged, even if its lanes would saturate.
- R10: With `sat_clr_i`=1, `sat_o` is 0 after the next rising edge, even if a saturating instruction is present in the same cycle.
- R11: `sat_o` is 0 while `rst_ni` is low and after reset is released.
- R12: In unsigned mode (`unsigned_mode_i`=1), a negative lane yields 0x00, a lane above 255 yields 0xFF, and both cases count as saturation. The lane order and the sticky behaviour are the same as in signed mode.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word; bit 31 is bit 0 in MSB numbering |
| unsigned_mode_i | input | 1 | 1 selects the unsigned byte clamp |
| src_a_i | input | 128 | Source A, eight signed halfwords |
| src_b_i | input | 128 | Source B, eight signed halfwords |
| sat_clr_i | input | 1 | Clears the sticky saturation bit |
| we_o | output | 1 | Destination write enable |
| dst_idx_o | output | 7 | Destination register index |
| src_a_idx_o | output | 7 | Source A register index |
| src_b_idx_o | output | 7 | Source B register index |
| result_o | output | 128 | Packed byte result |
| sat_o | output | 1 | Sticky saturation status |

## Verification
The lane assertions assume that `instr_i`, the sources and the mode input are stable around each rising edge, since the result path is purely combinational. The bench therefore changes every input on the falling edge. The sticky-bit assertions assume that `sat_clr_i` is a single-cycle request. The bench raises it for one cycle at a time and drops it before the next check, so that the hold and clear properties each see clean cycles.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
  localparam logic [31:0] STD_MASK  = 32'hFC00_07FF;
  localparam logic [31:0] STD_MATCH = 32'h1000_018E;
  // extended form: register-index bits (6..21, 26, 28..31 MSB-numbered) masked out
  localparam logic [31:0] EXT_MASK  = 32'hFC00_03D0;
  localparam logic [31:0] EXT_MATCH = 32'h1400_0200;
  localparam int unsigned EXT_IDX_W = 7;
  localparam int unsigned STD_IDX_W = 5;
endpackage

// File: rtl/vpk_decode.sv
module vpk_decode
  import vpk_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic [31:0]      instr_i,
  output logic             we_o,
  output logic [IDX_W-1:0] dst_idx_o,
  output logic [IDX_W-1:0] a_idx_o,
  output logic [IDX_W-1:0] b_idx_o
);
  logic std_hit, ext_hit;
  logic [STD_IDX_W-1:0] std_d, std_a, std_b;
  logic [EXT_IDX_W-1:0] ext_d, ext_a, ext_b;

  assign std_hit = (instr_i & STD_MASK) == STD_MATCH;
  assign ext_hit = (instr_i & EXT_MASK) == EXT_MATCH;
  assign we_o    = std_hit | ext_hit;

  assign std_d = instr_i[25:21];
  assign std_a = instr_i[20:16];
  assign std_b = instr_i[15:11];

  assign ext_d = {instr_i[3:2], instr_i[25:21]};
  assign ext_a = {instr_i[10], instr_i[5], instr_i[20:16]};
  assign ext_b = {instr_i[1:0], instr_i[15:11]};

  always_comb begin
    if (ext_hit) begin
      dst_idx_o = IDX_W'(ext_d);
      a_idx_o   = IDX_W'(ext_a);
      b_idx_o   = IDX_W'(ext_b);
    end else begin
      dst_idx_o = IDX_W'(std_d);
      a_idx_o   = IDX_W'(std_a);
      b_idx_o   = IDX_W'(std_b);
    end
  end
endmodule

// File: rtl/vpk_lane_clamp.sv
module vpk_lane_clamp #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 8
) (
  input  logic [IN_W-1:0]  lane_i,
  input  logic             unsigned_i,
  output logic [OUT_W-1:0] byte_o,
  output logic             sat_o
);
  localparam logic signed [IN_W-1:0] SMAX = IN_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] SMIN = -SMAX - 1;
  localparam logic signed [IN_W-1:0] UMAX = IN_W'((1 << OUT_W) - 1);

  logic signed [IN_W-1:0] v;
  logic hi, lo;

  assign v = $signed(lane_i);

  always_comb begin
    if (unsigned_i) begin
      lo = v < 0;
      hi = v > UMAX;
    end else begin
      lo = v < SMIN;
      hi = v > SMAX;
    end
    if (hi)      byte_o = unsigned_i ? {OUT_W{1'b1}} : {1'b0, {(OUT_W-1){1'b1}}};
    else if (lo) byte_o = unsigned_i ? {OUT_W{1'b0}} : {1'b1, {(OUT_W-1){1'b0}}};
    else         byte_o = lane_i[OUT_W-1:0];
  end

  assign sat_o = hi | lo;
endmodule

// File: rtl/vpk_sat_flag.sv
module vpk_sat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sat_o <= 1'b0;
    else if (clr_i) sat_o <= 1'b0;
    else if (set_i) sat_o <= 1'b1;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o && !clr_i |=> sat_o);
  // R10
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sat_o);
  // R7
  set_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_i |=> sat_o);
endmodule

// File: rtl/vpack_sat_unit.sv
module vpack_sat_unit #(
  parameter int unsigned LANES = 8,
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 8,
  parameter int unsigned IDX_W = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [31:0]                instr_i,
  input  logic                       unsigned_mode_i,
  input  logic [LANES*IN_W-1:0]      src_a_i,
  input  logic [LANES*IN_W-1:0]      src_b_i,
  input  logic                       sat_clr_i,
  output logic                       we_o,
  output logic [IDX_W-1:0]           dst_idx_o,
  output logic [IDX_W-1:0]           src_a_idx_o,
  output logic [IDX_W-1:0]           src_b_idx_o,
  output logic [2*LANES*OUT_W-1:0]   result_o,
  output logic                       sat_o
);
  localparam int unsigned SRC_W  = LANES * IN_W;
  localparam int unsigned RES_W  = 2 * LANES * OUT_W;
  localparam int unsigned NLANES = 2 * LANES;

  logic [NLANES-1:0] lane_sat;
  logic              sat_set;

  vpk_decode #(.IDX_W(IDX_W)) u_dec (
    .instr_i  (instr_i),
    .we_o     (we_o),
    .dst_idx_o(dst_idx_o),
    .a_idx_o  (src_a_idx_o),
    .b_idx_o  (src_b_idx_o)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int unsigned K = g % LANES;
    logic [IN_W-1:0]  lane;
    logic [OUT_W-1:0] res_byte;

    if (g < LANES) begin : g_a
      assign lane = src_a_i[SRC_W-1-K*IN_W -: IN_W];
    end else begin : g_b
      assign lane = src_b_i[SRC_W-1-K*IN_W -: IN_W];
    end

    vpk_lane_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clamp (
      .lane_i    (lane),
      .unsigned_i(unsigned_mode_i),
      .byte_o    (res_byte),
      .sat_o     (lane_sat[g])
    );

    assign result_o[RES_W-1-g*OUT_W -: OUT_W] = res_byte;

    // R1
    signed_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unsigned_mode_i && !lane_sat[g] |-> $signed(res_byte) == $signed(lane));
    // R12
    unsigned_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unsigned_mode_i && lane_sat[g] |-> (res_byte == '0 || res_byte == '1));
  end

  assign sat_set = we_o & (|lane_sat);

  vpk_sat_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sat_set),
    .clr_i (sat_clr_i),
    .sat_o (sat_o)
  );

  // R9
  idle_keeps_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o && !sat_clr_i |=> $stable(sat_o));
endmodule

// File: tb/tb_vpack_sat_unit.sv
module tb_vpack_sat_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  instr = '0;
  logic         umode = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic         clr = 1'b0;
  logic         we;
  logic [6:0]   di, ai, bi;
  logic [127:0] res;
  logic         sat;
  int n_chk = 0, n_fail = 0;

  localparam logic [31:0] STD_W = 32'h1000018E;
  localparam logic [31:0] EXT_W = 32'h14000200;

  always #2 clk = ~clk;

  vpack_sat_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .unsigned_mode_i(umode),
    .src_a_i(a), .src_b_i(b), .sat_clr_i(clr), .we_o(we), .dst_idx_o(di),
    .src_a_idx_o(ai), .src_b_idx_o(bi), .result_o(res), .sat_o(sat)
  );

  function automatic logic [7:0] clamp_ref(logic [15:0] h, logic u);
    int v = $signed(h);
    if (u) return (v < 0) ? 8'h00 : (v > 255) ? 8'hFF : h[7:0];
    return (v < -128) ? 8'h80 : (v > 127) ? 8'h7F : h[7:0];
  endfunction

  function automatic logic [127:0] pack_ref(logic [127:0] x, logic [127:0] y, logic u);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) begin
      r[127-8*k -: 8]      = clamp_ref(x[127-16*k -: 16], u);
      r[127-8*(k+8) -: 8]  = clamp_ref(y[127-16*k -: 16], u);
    end
    return r;
  endfunction

  // set field at MSB-numbered bit position p
  function automatic logic [31:0] put(logic [31:0] w, int p, int len, logic [6:0] v);
    for (int i = 0; i < len; i++) w[31-(p+len-1-i)] = v[i];
    return w;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] w, logic [127:0] x, logic [127:0] y, logic u, logic c);
    @(negedge clk);
    instr = w; a = x; b = y; umode = u; clr = c;
    #1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    check("R11 sat in reset", {127'b0, sat}, 128'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 sat after reset", {127'b0, sat}, 128'd0);
  endtask

  task automatic t_signed_corners();
    logic [127:0] x = {16'h0080, 16'hFF7F, 16'h007F, 16'hFF80, 16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF};
    logic [127:0] y = {16'h0005, 16'hFFFB, 16'h0100, 16'hFE00, 16'h0081, 16'hFF7E, 16'h0042, 16'hFFC0};
    drive(STD_W, x, y, 1'b0, 1'b0);
    check("R1 signed corners", res, 128'h7F807F807F8000FF05FB7F807F8042C0);
    drive(STD_W, '0, '0, 1'b0, 1'b1);
    drive(STD_W, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_order();
    drive(STD_W, {16'd0,16'd1,16'd2,16'd3,16'd4,16'd5,16'd6,16'd7},
                 {16'd8,16'd9,16'd10,16'd11,16'd12,16'd13,16'd14,16'd15}, 1'b0, 1'b0);
    check("R2 lane order", res, 128'h000102030405060708090A0B0C0D0E0F);
  endtask

  task automatic t_std_decode();
    logic [31:0] w = STD_W;
    w = put(w, 6, 5, 7'd3); w = put(w, 11, 5, 7'd17); w = put(w, 16, 5, 7'd30);
    drive(w, '0, '0, 1'b0, 1'b0);
    check("R3 std we", {127'b0, we}, 128'd1);
    check("R4 std indices", {107'b0, di, ai, bi}, {107'b0, 7'd3, 7'd17, 7'd30});
  endtask

  task automatic t_ext_decode();
    logic [31:0] w = EXT_W;
    w = put(w, 6, 5, 7'h15); w = put(w, 28, 2, 7'h2);
    w = put(w, 11, 5, 7'h0A); w = put(w, 21, 1, 7'h1); w = put(w, 26, 1, 7'h0);
    w = put(w, 16, 5, 7'h13); w = put(w, 30, 2, 7'h3);
    drive(w, '0, '0, 1'b0, 1'b0);
    check("R5 ext we", {127'b0, we}, 128'd1);
    check("R6 ext indices", {107'b0, di, ai, bi},
          {107'b0, 7'b1010101, 7'b1001010, 7'b1110011});
    w = put(w, 21, 1, 7'h0); w = put(w, 26, 1, 7'h1);
    drive(w, '0, '0, 1'b0, 1'b0);
    check("R6 ext A middle bit", {121'b0, ai}, {121'b0, 7'b0101010});
  endtask

  task automatic t_unknown();
    logic [127:0] hot = {8{16'h1234}};
    drive(STD_W ^ 32'h2, hot, hot, 1'b0, 1'b0);
    check("R9 bad xo we", {127'b0, we}, 128'd0);
    drive(EXT_W | 32'h10, hot, hot, 1'b0, 1'b0);
    check("R9 ext reserved we", {127'b0, we}, 128'd0);
    @(negedge clk);
    check("R9 sat untouched", {127'b0, sat}, 128'd0);
  endtask

  task automatic t_sticky();
    drive(STD_W, {8{16'h0200}}, '0, 1'b0, 1'b0);
    drive(STD_W, '0, '0, 1'b0, 1'b0);
    check("R7 sat set", {127'b0, sat}, 128'd1);
    @(negedge clk);
    check("R8 sat holds", {127'b0, sat}, 128'd1);
    drive(STD_W ^ 32'h2, '0, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 sat holds idle", {127'b0, sat}, 128'd1);
    drive(STD_W, '0, '0, 1'b0, 1'b1);
    drive(STD_W, '0, '0, 1'b0, 1'b0);
    check("R10 clear", {127'b0, sat}, 128'd0);
  endtask

  task automatic t_clear_priority();
    drive(EXT_W, '0, {8{16'h8000}}, 1'b0, 1'b1);
    drive(EXT_W, '0, '0, 1'b0, 1'b0);
    check("R10 clear beats set", {127'b0, sat}, 128'd0);
  endtask

  task automatic t_unsigned();
    logic [127:0] x = {16'hFFFF, 16'h0000, 16'h00FF, 16'h0100, 16'h8000, 16'h7FFF, 16'h0080, 16'h007F};
    drive(STD_W, x, {8{16'h0010}}, 1'b1, 1'b0);
    check("R12 unsigned clamp", res, 128'h0000FFFF00FF807F1010101010101010);
    drive(STD_W, '0, '0, 1'b1, 1'b0);
    check("R12 unsigned sat", {127'b0, sat}, 128'd1);
    drive(STD_W, {8{16'h00C8}}, '0, 1'b1, 1'b1);
    check("R12 no clamp 200", res[127:64], 64'hC8C8C8C8C8C8C8C8);
    drive(STD_W, '0, '0, 1'b1, 1'b0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      logic [127:0] x, y;
      for (int k = 0; k < 8; k++) begin
        x[16*k +: 16] = (i % 2) ? 16'($signed(10'($urandom))) : 16'($urandom);
        y[16*k +: 16] = (i % 3) ? 16'($signed(10'($urandom))) : 16'($urandom);
      end
      drive(EXT_W, x, y, 1'($urandom), 1'b0);
      check(umode ? "R12 random" : "R1 random", res, pack_ref(x, y, umode));
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    report();
  end

  initial begin
    t_reset();
    t_signed_corners();
    t_order();
    t_std_decode();
    t_ext_decode();
    t_unknown();
    t_sticky();
    t_clear_priority();
    t_unsigned();
    t_random();
    report();
  end
endmodule